// File: doc/BRIEF.md
# Power-Good System Reset with Watchdog

This block drives an active-low system reset for a board controller. It looks at two flags per rail, "reached power-good-on" and "fell below power-good-off", and at a set of general-purpose input levels. A mask picks which rails take part, and a second mask picks which inputs take part. Once every chosen rail is good and every chosen input is high, the reset waits a release delay and is then let go. The delay is picked from a power-of-two code table. In level mode the reset drops again at once when a chosen rail is lost or a chosen input goes low. In pulse mode the line rests high and gives one low pulse when power good is reached.

A watchdog timer also lives in the block. It starts only while the reset is released. It first waits an initial period picked from a second power-of-two table. After that it must be kept alive by any edge on an asynchronous kick pin or by a one-cycle kick command. When a period passes without a kick, the watchdog does one of three things, chosen by an action code. It can raise a separate watchdog output as a level. It can raise that output as a pulse. Or it can pull the system reset low for a pulse width and then run the release sequence again.

All timing counts a millisecond tick-enable input, so each "ms" below is one tick. A configuration-load strobe puts the block back into its checking state.

Top module: `sysrst_wdt`

## Requirements
- R1: In level mode (`cfg_pulse_mode`=0), `sys_rst_n` goes high only after every rail with its `rail_sel` bit set shows `rail_pg_on`=1 and every input with its `gpi_sel` bit set shows `gpi_lvl`=1. The release delay must then pass with these conditions held. Unselected rails and inputs have no effect.
- R2: Release delay code `cfg_rel_code`: code 0 gives 0 ticks, code k from 1 to 16 gives 2^(k-1) ticks, and any code above 16 acts as code 16 (32768 ticks).
- R3: In level mode, while the reset is released, a selected rail showing `rail_pg_off`=1 or a selected input going low makes `sys_rst_n` low on the next clock.
- R4: In pulse mode, `sys_rst_n` stays high while waiting. After the conditions and the release delay, it gives one low pulse of `cfg_pulse_ms` ticks (0 counts as 1) and then stays high. A later loss of conditions does not pull it low.
- R5: `sys_rst_n` is low in reset and for at least the first cycle after reset. It is also low in the cycle after a `cfg_load` strobe.
- R6: With `wdt_en`=1, the watchdog starts only while the reset is released. It first waits for start code `wdt_start_code`: code 0 gives 0 ticks and code k from 1 to 15 gives 100·2^(k-1) ticks. Only then does it time periods.
- R7: The watchdog times out after `wdt_period_ms` ticks (0 counts as 1) with no kick. Either edge of `wdt_kick_in`, which passes through a two-flop synchronizer, counts as a kick, and so does a one-cycle `wdt_kick_cmd`. A kick restarts the count.
- R8: Timeout action `wdt_action`: 00 and 11 hold `wdo` high until a kick. 01 drives `wdo` high for `cfg_pulse_ms` ticks. 10 leaves `wdo` low and pulls `sys_rst_n` low for `cfg_pulse_ms` ticks, then runs the release sequence again.
- R9: A kick after a timeout returns the watchdog to period timing at once, with no initial wait again.
- R10: With `wdt_en`=0, `wdo` is low and no timeout happens. Kicks during the initial wait have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | Millisecond tick enable, one cycle wide |
| rail_pg_on | input | N_RAIL | Rail has reached its power-good-on level |
| rail_pg_off | input | N_RAIL | Rail has dropped below its power-good-off level |
| rail_sel | input | N_RAIL | Rails that take part in the reset |
| gpi_lvl | input | N_GPI | Input levels, high means asserted |
| gpi_sel | input | N_GPI | Inputs that take part in the reset |
| cfg_load | input | 1 | Configuration change strobe |
| cfg_pulse_mode | input | 1 | 1 selects one-pulse mode |
| cfg_rel_code | input | 5 | Release delay code |
| cfg_pulse_ms | input | PW_W | Pulse width in ticks |
| wdt_en | input | 1 | Watchdog enable |
| wdt_start_code | input | 4 | Watchdog initial wait code |
| wdt_period_ms | input | PER_W | Watchdog period in ticks |
| wdt_action | input | 2 | Timeout action code |
| wdt_kick_in | input | 1 | Asynchronous kick pin, either edge |
| wdt_kick_cmd | input | 1 | Kick command strobe |
| sys_rst_n | output | 1 | Active-low system reset |
| wdo | output | 1 | Watchdog timeout output, active high |

## Verification
The hardest state to reach is the watchdog's reset-toggle path. The reset must be released first, then the watchdog must sit through its initial wait and a full silent period. Only then does the reset drop and come back through the release delay. The bench gets there by running the whole chain with short codes, measuring each stretch in ticks, and sending a kick on purpose during the initial wait. The top release code is reached by holding the tick high every cycle, so the 32768-tick clamp runs in bounded time.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int TCNT_W       = 32;
    localparam int REL_CODE_W   = 5;
    localparam int START_CODE_W = 4;
    localparam int REL_CODE_TOP = 16;
    localparam int START_BASE   = 100;

    typedef logic [TCNT_W-1:0] tcnt_t;

    typedef enum logic [2:0] {
        RS_CHECK,
        RS_HOLD,
        RS_DELAY,
        RS_PULSE,
        RS_RUN,
        RS_WDOG
    } rel_state_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_WAIT,
        WD_COUNT,
        WD_EXPIRED
    } wd_state_e;

    typedef enum logic [1:0] {
        WDA_LEVEL = 2'b00,
        WDA_PULSE = 2'b01,
        WDA_RESET = 2'b10,
        WDA_HOLD  = 2'b11
    } wd_action_e;

    typedef struct packed {
        logic ready;
        logic lost;
    } gate_t;

    typedef struct packed {
        rel_state_e st;
        tcnt_t      cnt;
    } rel_reg_t;

    typedef struct packed {
        wd_state_e st;
        tcnt_t     cnt;
    } wd_reg_t;

    function automatic tcnt_t rel_delay_ticks(input logic [REL_CODE_W-1:0] code);
        logic [REL_CODE_W-1:0] c;
        c = (code > REL_CODE_W'(REL_CODE_TOP)) ? REL_CODE_W'(REL_CODE_TOP) : code;
        if (c == '0) return '0;
        return tcnt_t'(1) << (c - REL_CODE_W'(1));
    endfunction

    function automatic tcnt_t start_wait_ticks(input logic [START_CODE_W-1:0] code);
        if (code == '0) return '0;
        return tcnt_t'(START_BASE) << (code - START_CODE_W'(1));
    endfunction

    function automatic tcnt_t at_least_one(input tcnt_t v);
        return (v == '0) ? tcnt_t'(1) : v;
    endfunction

endpackage

// File: rtl/sysrst_kick_sync.sv
module sysrst_kick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_async,
    input  logic kick_cmd,
    output logic kick
);

    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], kick_async};
    end

    // any edge seen past the synchronizer is a kick
    assign kick = (chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1]) | kick_cmd;

endmodule

// File: rtl/sysrst_gate.sv
module sysrst_gate
    import sysrst_pkg::*;
#(
    parameter int N_RAIL = 8,
    parameter int N_GPI  = 8
) (
    input  logic [N_RAIL-1:0] pg_on,
    input  logic [N_RAIL-1:0] pg_off,
    input  logic [N_RAIL-1:0] rail_sel,
    input  logic [N_GPI-1:0]  gpi_lvl,
    input  logic [N_GPI-1:0]  gpi_sel,
    output gate_t             gate
);

    logic [N_RAIL-1:0] rail_ok;
    logic [N_RAIL-1:0] rail_bad;
    logic [N_GPI-1:0]  gpi_ok;

    for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
        assign rail_ok[i]  = !rail_sel[i] || pg_on[i];
        assign rail_bad[i] = rail_sel[i] && pg_off[i];
    end

    for (genvar j = 0; j < N_GPI; j++) begin : g_gpi
        assign gpi_ok[j] = !gpi_sel[j] || gpi_lvl[j];
    end

    assign gate.ready = (&rail_ok) && (&gpi_ok);
    assign gate.lost  = (|rail_bad) || !(&gpi_ok);

endmodule

// File: rtl/sysrst_release.sv
module sysrst_release
    import sysrst_pkg::*;
#(
    parameter int PW_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cfg_load,
    input  gate_t                 gate,
    input  logic                  pulse_mode,
    input  logic [REL_CODE_W-1:0] rel_code,
    input  logic [PW_W-1:0]       pw_ms,
    input  logic                  wd_toggle,
    output logic                  rst_n,
    output logic                  running
);

    rel_reg_t q, d;
    tcnt_t    dly_t;
    tcnt_t    pw_t;

    assign dly_t = rel_delay_ticks(rel_code);
    assign pw_t  = at_least_one(tcnt_t'(pw_ms));

    always_comb begin
        d = q;
        if (cfg_load) begin
            d.st  = RS_CHECK;
            d.cnt = '0;
        end else begin
            case (q.st)
                RS_CHECK: begin
                    d.st  = RS_HOLD;
                    d.cnt = '0;
                end
                RS_HOLD: begin
                    if (gate.ready) begin
                        d.st  = RS_DELAY;
                        d.cnt = '0;
                    end
                end
                RS_DELAY: begin
                    if (!gate.ready) begin
                        d.st  = RS_HOLD;
                        d.cnt = '0;
                    end else if (q.cnt >= dly_t) begin
                        d.st  = pulse_mode ? RS_PULSE : RS_RUN;
                        d.cnt = '0;
                    end else if (tick) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                RS_PULSE: begin
                    if (q.cnt >= pw_t) begin
                        d.st  = RS_RUN;
                        d.cnt = '0;
                    end else if (tick) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                RS_RUN: begin
                    if (gate.lost) begin
                        d.st  = RS_HOLD;
                        d.cnt = '0;
                    end else if (wd_toggle) begin
                        d.st  = RS_WDOG;
                        d.cnt = '0;
                    end
                end
                RS_WDOG: begin
                    if (q.cnt >= pw_t) begin
                        d.st  = RS_HOLD;
                        d.cnt = '0;
                    end else if (tick) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                default: begin
                    d.st  = RS_CHECK;
                    d.cnt = '0;
                end
            endcase
        end
    end

    function automatic logic line_level(input rel_state_e s, input logic pm);
        case (s)
            RS_RUN:             return 1'b1;
            RS_HOLD, RS_DELAY:  return pm;
            default:            return 1'b0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= RS_CHECK;
            q.cnt <= '0;
            rst_n <= 1'b0;
        end else begin
            q     <= d;
            rst_n <= line_level(d.st, pulse_mode);
        end
    end

    assign running = (q.st == RS_RUN);

endmodule

// File: rtl/sysrst_watchdog.sv
module sysrst_watchdog
    import sysrst_pkg::*;
#(
    parameter int PER_W = 18,
    parameter int PW_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    cfg_load,
    input  logic                    en,
    input  logic                    armed,
    input  logic                    kick,
    input  logic [START_CODE_W-1:0] start_code,
    input  logic [PER_W-1:0]        period_ms,
    input  logic [1:0]              action,
    input  logic [PW_W-1:0]         pw_ms,
    output logic                    wdo,
    output logic                    toggle_req
);

    wd_reg_t    q, d;
    tcnt_t      wait_t;
    tcnt_t      per_t;
    tcnt_t      pw_t;
    wd_action_e act;
    logic       live;
    logic       expire;

    assign wait_t = start_wait_ticks(start_code);
    assign per_t  = at_least_one(tcnt_t'(period_ms));
    assign pw_t   = at_least_one(tcnt_t'(pw_ms));
    assign act    = wd_action_e'(action);
    assign live   = en && armed && !cfg_load;
    assign expire = live && (q.st == WD_COUNT) && !kick && tick
                    && ((q.cnt + tcnt_t'(1)) >= per_t);

    always_comb begin
        d = q;
        if (!live) begin
            d.st  = WD_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                WD_IDLE: begin
                    d.st  = WD_WAIT;
                    d.cnt = '0;
                end
                WD_WAIT: begin
                    if (q.cnt >= wait_t) begin
                        d.st  = WD_COUNT;
                        d.cnt = '0;
                    end else if (tick) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                WD_COUNT: begin
                    if (kick) begin
                        d.cnt = '0;
                    end else if (expire) begin
                        d.st  = WD_EXPIRED;
                        d.cnt = '0;
                    end else if (tick) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                WD_EXPIRED: begin
                    if (kick) begin
                        d.st  = WD_COUNT;
                        d.cnt = '0;
                    end else if (tick && (q.cnt < pw_t)) begin
                        d.cnt = q.cnt + tcnt_t'(1);
                    end
                end
                default: begin
                    d.st  = WD_IDLE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    function automatic logic out_level(input wd_reg_t r, input wd_action_e a, input tcnt_t w);
        if (r.st != WD_EXPIRED) return 1'b0;
        case (a)
            WDA_PULSE: return r.cnt < w;
            WDA_RESET: return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= WD_IDLE;
            q.cnt <= '0;
            wdo   <= 1'b0;
        end else begin
            q   <= d;
            wdo <= out_level(d, act, pw_t);
        end
    end

    assign toggle_req = expire && (act == WDA_RESET);

endmodule

// File: rtl/sysrst_wdt.sv
module sysrst_wdt
    import sysrst_pkg::*;
#(
    parameter int N_RAIL      = 8,
    parameter int N_GPI       = 8,
    parameter int PER_W       = 18,
    parameter int PW_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_ms,
    input  logic [N_RAIL-1:0]       rail_pg_on,
    input  logic [N_RAIL-1:0]       rail_pg_off,
    input  logic [N_RAIL-1:0]       rail_sel,
    input  logic [N_GPI-1:0]        gpi_lvl,
    input  logic [N_GPI-1:0]        gpi_sel,
    input  logic                    cfg_load,
    input  logic                    cfg_pulse_mode,
    input  logic [REL_CODE_W-1:0]   cfg_rel_code,
    input  logic [PW_W-1:0]         cfg_pulse_ms,
    input  logic                    wdt_en,
    input  logic [START_CODE_W-1:0] wdt_start_code,
    input  logic [PER_W-1:0]        wdt_period_ms,
    input  logic [1:0]              wdt_action,
    input  logic                    wdt_kick_in,
    input  logic                    wdt_kick_cmd,
    output logic                    sys_rst_n,
    output logic                    wdo
);

    gate_t gate;
    logic  kick;
    logic  running;
    logic  wd_toggle;

    sysrst_gate #(.N_RAIL(N_RAIL), .N_GPI(N_GPI)) u_gate (
        .pg_on    (rail_pg_on),
        .pg_off   (rail_pg_off),
        .rail_sel (rail_sel),
        .gpi_lvl  (gpi_lvl),
        .gpi_sel  (gpi_sel),
        .gate     (gate)
    );

    sysrst_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
        .clk        (clk),
        .rst        (rst),
        .kick_async (wdt_kick_in),
        .kick_cmd   (wdt_kick_cmd),
        .kick       (kick)
    );

    sysrst_release #(.PW_W(PW_W)) u_rel (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_ms),
        .cfg_load   (cfg_load),
        .gate       (gate),
        .pulse_mode (cfg_pulse_mode),
        .rel_code   (cfg_rel_code),
        .pw_ms      (cfg_pulse_ms),
        .wd_toggle  (wd_toggle),
        .rst_n      (sys_rst_n),
        .running    (running)
    );

    sysrst_watchdog #(.PER_W(PER_W), .PW_W(PW_W)) u_wd (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_ms),
        .cfg_load   (cfg_load),
        .en         (wdt_en),
        .armed      (running),
        .kick       (kick),
        .start_code (wdt_start_code),
        .period_ms  (wdt_period_ms),
        .action     (wdt_action),
        .pw_ms      (cfg_pulse_ms),
        .wdo        (wdo),
        .toggle_req (wd_toggle)
    );

endmodule

// File: rtl/sysrst_wdt_chk.sv
module sysrst_wdt_chk #(
    parameter int N_RAIL = 8,
    parameter int N_GPI  = 8,
    parameter int PW_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic              cfg_pulse_mode,
    input logic [N_RAIL-1:0] rail_pg_on,
    input logic [N_RAIL-1:0] rail_pg_off,
    input logic [N_RAIL-1:0] rail_sel,
    input logic [N_GPI-1:0]  gpi_lvl,
    input logic [N_GPI-1:0]  gpi_sel,
    input logic              wdt_en,
    input logic [1:0]        wdt_action,
    input logic [PW_W-1:0]   cfg_pulse_ms,
    input logic              wdt_kick_cmd,
    input logic              sys_rst_n,
    input logic              wdo
);

    logic ready_c;
    logic lost_c;

    assign ready_c = (&(rail_pg_on | ~rail_sel)) && (&(gpi_lvl | ~gpi_sel));
    assign lost_c  = (|(rail_pg_off & rail_sel)) || !(&(gpi_lvl | ~gpi_sel));

    AST_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sys_rst_n); // R5

    AST_LOW_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !sys_rst_n); // R5

    AST_RELEASE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        ($rose(sys_rst_n) && !cfg_pulse_mode && $past(!cfg_pulse_mode)) |-> $past(ready_c)); // R1

    AST_LOSS_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_pulse_mode && sys_rst_n && lost_c) |=> (!sys_rst_n || cfg_pulse_mode)); // R3

    AST_WDO_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n |=> !wdo); // R6

    AST_WDO_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdo); // R10

    AST_NO_EXPIRE_ON_KICK: assert property (@(posedge clk) disable iff (rst)
        ($rose(wdo) && $stable(wdt_action) && $stable(cfg_pulse_ms)) |-> !$past(wdt_kick_cmd)); // R7

endmodule

bind sysrst_wdt sysrst_wdt_chk #(.N_RAIL(N_RAIL), .N_GPI(N_GPI), .PW_W(PW_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_load       (cfg_load),
    .cfg_pulse_mode (cfg_pulse_mode),
    .rail_pg_on     (rail_pg_on),
    .rail_pg_off    (rail_pg_off),
    .rail_sel       (rail_sel),
    .gpi_lvl        (gpi_lvl),
    .gpi_sel        (gpi_sel),
    .wdt_en         (wdt_en),
    .wdt_action     (wdt_action),
    .cfg_pulse_ms   (cfg_pulse_ms),
    .wdt_kick_cmd   (wdt_kick_cmd),
    .sys_rst_n      (sys_rst_n),
    .wdo            (wdo)
);

// File: tb/sysrst_wdt_tb.sv
module sysrst_wdt_tb;

    localparam int NR = 8;
    localparam int NG = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          tick_ms;
    logic [NR-1:0] rail_pg_on, rail_pg_off, rail_sel;
    logic [NG-1:0] gpi_lvl, gpi_sel;
    logic          cfg_load, cfg_pulse_mode;
    logic [4:0]    cfg_rel_code;
    logic [15:0]   cfg_pulse_ms;
    logic          wdt_en;
    logic [3:0]    wdt_start_code;
    logic [17:0]   wdt_period_ms;
    logic [1:0]    wdt_action;
    logic          wdt_kick_in, wdt_kick_cmd;
    logic          sys_rst_n, wdo;

    sysrst_wdt u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms),
        .rail_pg_on(rail_pg_on), .rail_pg_off(rail_pg_off), .rail_sel(rail_sel),
        .gpi_lvl(gpi_lvl), .gpi_sel(gpi_sel),
        .cfg_load(cfg_load), .cfg_pulse_mode(cfg_pulse_mode),
        .cfg_rel_code(cfg_rel_code), .cfg_pulse_ms(cfg_pulse_ms),
        .wdt_en(wdt_en), .wdt_start_code(wdt_start_code),
        .wdt_period_ms(wdt_period_ms), .wdt_action(wdt_action),
        .wdt_kick_in(wdt_kick_in), .wdt_kick_cmd(wdt_kick_cmd),
        .sys_rst_n(sys_rst_n), .wdo(wdo)
    );

    int tick_div = 4;
    int tick_cnt = 0;
    int phase    = 0;
    int n_chk    = 0;
    int n_bad    = 0;

    // tick driver, changes just after the rising edge
    initial begin
        tick_ms = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (tick_div <= 1) tick_ms = 1'b1;
            else begin
                phase   = (phase + 1) % tick_div;
                tick_ms = (phase == 0);
            end
            if (tick_ms) tick_cnt++;
        end
    end

    function automatic int exp_rel(input int code);
        int c = (code > 16) ? 16 : code;
        int v = 1;
        if (c == 0) return 0;
        for (int i = 1; i < c; i++) v = v * 2;
        return v;
    endfunction

    function automatic int exp_wait(input int code);
        int v = 100;
        if (code == 0) return 0;
        for (int i = 1; i < code; i++) v = v * 2;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int t0 = tick_cnt;
        while (tick_cnt - t0 < n) @(negedge clk);
    endtask

    task automatic wait_rst(input logic val, input int max_cyc, output int ticks, output bit seen);
        int t0 = tick_cnt;
        seen = 1'b0;
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (sys_rst_n === val) begin seen = 1'b1; break; end
        end
        ticks = tick_cnt - t0;
    endtask

    task automatic wait_wdo(input logic val, input int max_cyc, output int ticks, output bit seen);
        int t0 = tick_cnt;
        seen = 1'b0;
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (wdo === val) begin seen = 1'b1; break; end
        end
        ticks = tick_cnt - t0;
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic pulse_kick();
        wdt_kick_cmd = 1'b1;
        @(negedge clk);
        wdt_kick_cmd = 1'b0;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int  t, d, k, t0;
        bit  seen;
        logic [NR-1:0] rs;
        logic [NG-1:0] gs;

        void'($urandom(32'd20240611));
        rst = 1'b1;
        rail_pg_on = '0; rail_pg_off = '0; rail_sel = '0;
        gpi_lvl = '0; gpi_sel = '0;
        cfg_load = 1'b0; cfg_pulse_mode = 1'b0; cfg_rel_code = '0; cfg_pulse_ms = 16'd4;
        wdt_en = 1'b0; wdt_start_code = '0; wdt_period_ms = 18'd10; wdt_action = 2'b00;
        wdt_kick_in = 1'b0; wdt_kick_cmd = 1'b0;

        repeat (3) @(negedge clk);
        check(sys_rst_n === 1'b0, "R5 line low in reset", sys_rst_n, 0);
        check(wdo === 1'b0, "R10 wdo low in reset", wdo, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sys_rst_n === 1'b0, "R5 line low after reset", sys_rst_n, 0);

        // random release / loss sweeps
        for (int it = 0; it < 6; it++) begin
            rs = NR'($urandom);
            if (rs == '0) rs = NR'(1);
            gs = NG'($urandom);
            d  = $urandom_range(0, 6);
            k  = 0;
            for (int b = NR - 1; b >= 0; b--) if (rs[b]) k = b;
            rail_sel = rs; gpi_sel = gs; cfg_rel_code = 5'(d);
            rail_pg_on  = (rs & ~(NR'(1) << k)) | (NR'($urandom) & ~rs);
            rail_pg_off = NR'($urandom) & ~rs;
            gpi_lvl     = gs | (NG'($urandom) & ~gs);
            wait_ticks(exp_rel(d) + 4);
            check(sys_rst_n === 1'b0, "R1 held while one selected rail not good", sys_rst_n, 0);
            rail_pg_on[k] = 1'b1;
            wait_rst(1'b1, 2000, t, seen);
            check(seen, "R1 released when conditions met", seen, 1);
            check(t >= exp_rel(d) && t <= exp_rel(d) + 2, "R2 release delay ticks", t, exp_rel(d));
            rail_pg_off = rail_pg_off | ~rs;
            gpi_lvl     = gpi_lvl & gs;
            wait_ticks(3);
            check(sys_rst_n === 1'b1, "R1 unselected lines ignored", sys_rst_n, 1);
            rail_pg_off = '0;
            @(negedge clk);
            if ((it % 2 == 1) && (gs != '0)) begin
                gpi_lvl = '0;
            end else begin
                rail_pg_off[k] = 1'b1;
                rail_pg_on[k]  = 1'b0;
            end
            @(negedge clk);
            check(sys_rst_n === 1'b0, "R3 loss drops line next clock", sys_rst_n, 0);
            rail_pg_on = '0; rail_pg_off = '0; gpi_lvl = '0;
            repeat (2) @(negedge clk);
        end

        // clamp of the top code, tick every cycle
        tick_div = 1;
        rail_sel = NR'(1); gpi_sel = '0; cfg_rel_code = 5'd20;
        @(negedge clk);
        rail_pg_on = NR'(1);
        wait_rst(1'b1, 40000, t, seen);
        check(seen && t >= 32768 && t <= 32770, "R2 code above 16 clamps to 32768", t, 32768);
        tick_div = 4;
        cfg_rel_code = 5'd2;

        // configuration load in run
        pulse_load();
        check(sys_rst_n === 1'b0, "R5 line low after cfg_load", sys_rst_n, 0);
        wait_rst(1'b1, 200, t, seen);
        check(seen, "R5 line released again after load", seen, 1);

        // pulse mode
        cfg_pulse_mode = 1'b1; cfg_rel_code = 5'd3; cfg_pulse_ms = 16'd3;
        rail_pg_on = '0;
        pulse_load();
        @(negedge clk);
        check(sys_rst_n === 1'b1, "R4 line rests high in pulse mode", sys_rst_n, 1);
        rail_pg_on = NR'(1);
        wait_rst(1'b0, 400, t, seen);
        check(seen && t >= 4 && t <= 6, "R4 pulse starts after release delay", t, 4);
        wait_rst(1'b1, 400, t, seen);
        check(seen && t >= 3 && t <= 5, "R4 pulse width ticks", t, 3);
        wait_ticks(20);
        check(sys_rst_n === 1'b1, "R4 only one pulse", sys_rst_n, 1);
        rail_pg_off = NR'(1); rail_pg_on = '0;
        repeat (5) @(negedge clk);
        check(sys_rst_n === 1'b1, "R4 loss does not pull line low", sys_rst_n, 1);

        // back to level mode, released
        cfg_pulse_mode = 1'b0; cfg_rel_code = 5'd1; cfg_pulse_ms = 16'd4;
        rail_pg_off = '0; rail_pg_on = NR'(1);
        pulse_load();
        wait_rst(1'b1, 200, t, seen);
        check(seen, "R1 level release before watchdog", seen, 1);

        // watchdog start wait with an ignored kick
        wdt_start_code = 4'd1; wdt_period_ms = 18'd10; wdt_action = 2'b00;
        t0 = tick_cnt;
        wdt_en = 1'b1;
        wait_ticks(50);
        pulse_kick();
        wait_wdo(1'b1, 3000, t, seen);
        t = tick_cnt - t0;
        check(seen && t >= exp_wait(1) + 9 && t <= exp_wait(1) + 13,
              "R6 R10 start wait then period, wait kick ignored", t, exp_wait(1) + 10);
        wait_ticks(20);
        check(wdo === 1'b1, "R8 level action holds wdo", wdo, 1);
        pulse_kick();
        check(wdo === 1'b0, "R9 kick clears timeout", wdo, 0);
        wait_wdo(1'b1, 400, t, seen);
        check(seen && t >= 9 && t <= 13, "R9 next timeout without start wait", t, 10);

        // kicks by pin edges keep it alive
        pulse_kick();
        for (int i = 0; i < 12; i++) begin
            wait_ticks(5);
            wdt_kick_in = ~wdt_kick_in;
        end
        check(wdo === 1'b0, "R7 pin edges keep watchdog alive", wdo, 0);
        for (int i = 0; i < 8; i++) begin
            wait_ticks(5);
            pulse_kick();
        end
        check(wdo === 1'b0, "R7 kick commands keep watchdog alive", wdo, 0);
        wait_wdo(1'b1, 400, t, seen);
        check(seen && t >= 9 && t <= 13, "R7 timeout after silent period", t, 10);

        // pulse action
        pulse_kick();
        wdt_action = 2'b01;
        wait_wdo(1'b1, 400, t, seen);
        wait_wdo(1'b0, 400, t, seen);
        check(seen && t >= 3 && t <= 6, "R8 wdo pulse width", t, 4);
        wait_ticks(10);
        check(wdo === 1'b0, "R8 wdo pulse stays low after width", wdo, 0);

        // reset-toggle action
        pulse_kick();
        wdt_action = 2'b10;
        wait_rst(1'b0, 400, t, seen);
        check(seen, "R8 timeout pulls reset low", seen, 1);
        check(wdo === 1'b0, "R8 wdo stays low in reset action", wdo, 0);
        wait_rst(1'b1, 400, t, seen);
        check(seen && t >= 4 && t <= 8, "R8 reset low for width then release delay", t, 5);

        // disable
        wdt_en = 1'b0;
        wait_ticks(200);
        check(wdo === 1'b0 && sys_rst_n === 1'b1, "R10 disabled watchdog never times out",
              {wdo, sys_rst_n}, 1);

        finish_up();
    end

endmodule